// File: doc/BRIEF.md
# Helicity Window Subblock Integrator

This block integrates a continuous stream of signed ADC samples over one helicity window. A start strobe opens the window, and the window length in samples is given at the same moment. While the window is open, every valid sample is sign-extended to 64 bits and added into nine accumulators at once:

- the window total;
- four time-ordered subblocks, one for each consecutive quarter of the window;
- four interleaved subblocks, where each sample goes to the subblock given by its position modulo four.

A free-running timestamp is captured when the start strobe is accepted.

When the final sample of the window is accepted, all sums are copied into a result bank in one step. The result bank also takes the sample count, the timestamp and a flag that marks a window length that is not a multiple of four. A one-cycle valid pulse marks new results. The accumulators are separate from the result bank, so the next window may open on the very next cycle while the finished results stay readable.

Top module: `hwin_integrator`

## Requirements
- R1: A start strobe with a nonzero window length N, taken while no window is open, opens a window. The sample present in that same cycle (if its valid bit is high) is sample index 0. Cycles with the valid bit low are skipped, and the window closes on the N-th accepted sample. The reported count equals N.
- R2: The total equals the sum of the N samples, each read as an 18-bit two's-complement value and sign-extended to 64 bits.
- R3: With Q = floor(N/4), sample index i (counted from 0) is added to time-ordered subblock min(floor(i/Q), 3). When Q = 0, every sample goes to time-ordered subblock 3.
- R4: Sample index i is added to interleaved subblock (i mod 4). Subblock 0 therefore holds indices 0, 4, 8 and so on.
- R5: The reported timestamp is the value of the timestamp input in the cycle where the start strobe was accepted.
- R6: In the cycle after the final sample is accepted, the result bank is updated and the valid output is high for exactly that one cycle. The results then hold unchanged until the next window closes.
- R7: The length-error output reads 1 when N mod 4 is not 0, and 0 otherwise.
- R8: A start strobe is ignored while a window is open. A start strobe with N = 0 is ignored.
- R9: A new window may be opened in the cycle right after the previous window's final sample. Both windows then report correct, independent results.
- R10: While reset is active and after it is released, the valid output and every result output read 0 until a window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Opens a window when no window is open |
| winLen | input | LEN_W | Window length in samples, sampled with the start strobe |
| sampleValid | input | 1 | The sample on sampleData is present this cycle |
| sampleData | input | SAMPLE_W | Signed two's-complement ADC sample |
| timeNow | input | TS_W | Free-running timestamp |
| resValid | output | 1 | One-cycle pulse when new results are loaded |
| resTotal | output | ACC_W | Sum of the whole window |
| resTime | output | 4 x ACC_W | Time-ordered quarter sums, index 0 in the low word |
| resIlv | output | 4 x ACC_W | Interleaved modulo-4 sums, index 0 in the low word |
| resStamp | output | TS_W | Timestamp captured at the window start |
| resCount | output | LEN_W | Number of samples accumulated |
| resLenErr | output | 1 | The window length was not a multiple of four |

## Verification
Each wrong internal state shows up at the ports within one cycle after the affected window closes:

- A wrong quarter index, or a quarter boundary that advances late, moves a sample between two time-ordered sums. The total and its sum over the four quarters stay consistent, but the individual quarter values are wrong.
- A slip in the sample counter either closes the window early or late, which moves the valid pulse and changes the reported count, or misroutes the interleaved sums.
- A missed clear of the accumulators on a back-to-back start carries the old sums into the next result.

The bench applies windows with gaps in the valid bit, with lengths below four and with lengths that are not a multiple of four, and with extreme negative samples, so that each of these faults reaches a compared value.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

  // Number of time-ordered and of interleaved subblocks (behaviour assumes 4)
  localparam int SUB_COUNT = 4;
  localparam int SEL_W     = $clog2(SUB_COUNT);

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic             clear;    // window opens this cycle: zero accumulators
    logic             accum;    // a sample is accepted this cycle
    logic [SEL_W-1:0] timeSel;  // time-ordered subblock for the sample
    logic [SEL_W-1:0] ilvSel;   // interleaved subblock for the sample
    logic             finish;   // this sample is the last of the window
    logic             lenErr;   // window length not a multiple of SUB_COUNT
  } hwinCtrl_t;

endpackage

// File: rtl/hwin_ctrl.sv
module hwin_ctrl
  import hwin_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] winLen,
  input  logic             sampleValid,
  output hwinCtrl_t        ctrl
);

  localparam logic [SEL_W-1:0] LAST_SUB = SEL_W'(SUB_COUNT - 1);

  logic             busy;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] qLenReg;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] inQ;
  logic [SEL_W-1:0] quarter;

  // Context for this cycle: fresh values on a start, stored values otherwise
  logic             starting;
  logic             open;
  logic             accept;
  logic             last;
  logic             quarterEnd;
  logic [LEN_W-1:0] startQLen;
  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] effQLen;
  logic [LEN_W-1:0] effCnt;
  logic [LEN_W-1:0] effInQ;
  logic [SEL_W-1:0] effQ;

  always_comb begin
    starting   = startPulse && !busy && (winLen != '0);
    startQLen  = winLen >> SEL_W;
    effLen     = starting ? winLen : lenReg;
    effQLen    = starting ? startQLen : qLenReg;
    effCnt     = starting ? '0 : cnt;
    effInQ     = starting ? '0 : inQ;
    if (starting) effQ = (startQLen == '0) ? LAST_SUB : '0;
    else          effQ = quarter;
    open       = starting || busy;
    accept     = open && sampleValid;
    last       = accept && (effCnt == effLen - LEN_W'(1));
    quarterEnd = (effQ != LAST_SUB) && (effInQ == effQLen - LEN_W'(1));
  end

  always_comb begin
    ctrl.clear   = starting;
    ctrl.accum   = accept;
    ctrl.timeSel = effQ;
    ctrl.ilvSel  = effCnt[SEL_W-1:0];
    ctrl.finish  = last;
    ctrl.lenErr  = (effLen[SEL_W-1:0] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      lenReg  <= '0;
      qLenReg <= '0;
      cnt     <= '0;
      inQ     <= '0;
      quarter <= '0;
    end else begin
      busy <= open && !last;
      if (starting) begin
        lenReg  <= winLen;
        qLenReg <= startQLen;
      end
      if (open) begin
        if (accept) begin
          cnt <= effCnt + LEN_W'(1);
          if (quarterEnd) begin
            quarter <= effQ + SEL_W'(1);
            inQ     <= '0;
          end else begin
            quarter <= effQ;
            inQ     <= effInQ + LEN_W'(1);
          end
        end else begin
          cnt     <= effCnt;
          quarter <= effQ;
          inQ     <= effInQ;
        end
      end
    end
  end

  // R1: an open window never has more samples counted than its length
  a_r1_count_below_len: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < lenReg));

  // R8: a start strobe during an open window leaves the stored length alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse) |=> $stable(lenReg));

  // R3: within one window the time-ordered index never goes back
  a_r3_quarter_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (quarter >= $past(quarter)));

  // R6: closing a window always leaves the unit idle
  a_r6_finish_goes_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> !busy);

endmodule

// File: rtl/hwin_datapath.sv
module hwin_datapath
  import hwin_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int ACC_W    = 64,
  parameter int TS_W     = 48,
  parameter int CNT_W    = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  hwinCtrl_t                         ctrl,
  input  logic [SAMPLE_W-1:0]               sampleData,
  input  logic [TS_W-1:0]                   timeNow,
  output logic                              resValid,
  output logic [ACC_W-1:0]                  resTotal,
  output logic [SUB_COUNT-1:0][ACC_W-1:0]   resTime,
  output logic [SUB_COUNT-1:0][ACC_W-1:0]   resIlv,
  output logic [TS_W-1:0]                   resStamp,
  output logic [CNT_W-1:0]                  resCount,
  output logic                              resLenErr
);

  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic [ACC_W-1:0]                sampleExt;
  logic [ACC_W-1:0]                addTerm;
  logic [ACC_W-1:0]                accTotal, nxtTotal;
  logic [SUB_COUNT-1:0][ACC_W-1:0] accTime, nxtTime;
  logic [SUB_COUNT-1:0][ACC_W-1:0] accIlv, nxtIlv;
  logic [CNT_W-1:0]                accCount, nxtCount;
  logic [TS_W-1:0]                 stampReg, nxtStamp;

  always_comb begin
    sampleExt = {{EXT_W{sampleData[SAMPLE_W-1]}}, sampleData};
    addTerm   = ctrl.accum ? sampleExt : '0;
    nxtTotal  = (ctrl.clear ? '0 : accTotal) + addTerm;
    nxtCount  = (ctrl.clear ? '0 : accCount) + CNT_W'(ctrl.accum);
    nxtStamp  = ctrl.clear ? timeNow : stampReg;
  end

  for (genvar g = 0; g < SUB_COUNT; g++) begin : g_sub
    always_comb begin
      nxtTime[g] = (ctrl.clear ? '0 : accTime[g]) +
                   ((ctrl.timeSel == SEL_W'(g)) ? addTerm : '0);
      nxtIlv[g]  = (ctrl.clear ? '0 : accIlv[g]) +
                   ((ctrl.ilvSel == SEL_W'(g)) ? addTerm : '0);
    end
  end

  // Working accumulators
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accTotal <= '0;
      accTime  <= '0;
      accIlv   <= '0;
      accCount <= '0;
      stampReg <= '0;
    end else if (ctrl.clear || ctrl.accum) begin
      accTotal <= nxtTotal;
      accTime  <= nxtTime;
      accIlv   <= nxtIlv;
      accCount <= nxtCount;
      stampReg <= nxtStamp;
    end
  end

  // Result bank, loaded once per window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resTotal  <= '0;
      resTime   <= '0;
      resIlv    <= '0;
      resStamp  <= '0;
      resCount  <= '0;
      resLenErr <= 1'b0;
    end else begin
      resValid <= ctrl.finish;
      if (ctrl.finish) begin
        resTotal  <= nxtTotal;
        resTime   <= nxtTime;
        resIlv    <= nxtIlv;
        resStamp  <= nxtStamp;
        resCount  <= nxtCount;
        resLenErr <= ctrl.lenErr;
      end
    end
  end

  // Sums over the subblock banks, used by the checks below
  logic [ACC_W-1:0] timeSum, ilvSum;
  always_comb begin
    timeSum = '0;
    ilvSum  = '0;
    for (int k = 0; k < SUB_COUNT; k++) begin
      timeSum = timeSum + resTime[k];
      ilvSum  = ilvSum + resIlv[k];
    end
  end

  // R3: the time-ordered subblocks add up to the total
  a_r3_time_sum_total: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (timeSum == resTotal));

  // R4: the interleaved subblocks add up to the total
  a_r4_ilv_sum_total: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (ilvSum == resTotal));

  // R1: a finished window always reports at least one sample
  a_r1_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCount != '0));

  // R6: results change only together with the valid pulse
  a_r6_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resTotal) && $stable(resStamp) && $stable(resCount)));

endmodule

// File: rtl/hwin_integrator.sv
module hwin_integrator
  import hwin_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int ACC_W    = 64,
  parameter int TS_W     = 48,
  parameter int LEN_W    = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            startPulse,
  input  logic [LEN_W-1:0]                winLen,
  input  logic                            sampleValid,
  input  logic [SAMPLE_W-1:0]             sampleData,
  input  logic [TS_W-1:0]                 timeNow,
  output logic                            resValid,
  output logic [ACC_W-1:0]                resTotal,
  output logic [SUB_COUNT-1:0][ACC_W-1:0] resTime,
  output logic [SUB_COUNT-1:0][ACC_W-1:0] resIlv,
  output logic [TS_W-1:0]                 resStamp,
  output logic [LEN_W-1:0]                resCount,
  output logic                            resLenErr
);

  hwinCtrl_t ctrl;

  hwin_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .winLen     (winLen),
    .sampleValid(sampleValid),
    .ctrl       (ctrl)
  );

  hwin_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .ACC_W   (ACC_W),
    .TS_W    (TS_W),
    .CNT_W   (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .sampleData(sampleData),
    .timeNow   (timeNow),
    .resValid  (resValid),
    .resTotal  (resTotal),
    .resTime   (resTime),
    .resIlv    (resIlv),
    .resStamp  (resStamp),
    .resCount  (resCount),
    .resLenErr (resLenErr)
  );

  // R6: the last accepted sample is followed by a valid pulse
  a_r6_valid_after_last: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> resValid);

  // R10: no valid pulse without a window closing
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> !resValid);

endmodule

// File: tb/hwin_integrator_bench.sv
module hwin_integrator_bench;

  localparam int SAMPLE_W = 18;
  localparam int ACC_W    = 64;
  localparam int TS_W     = 48;
  localparam int LEN_W    = 16;

  typedef struct packed {
    int len;
    int base;
    int step;
    int gap;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16,   100,     7,     0},
    '{12,   -500,    3,     2},
    '{6,    1000,    -400,  0},
    '{3,    5,       1,     0},
    '{1,    -131072, 0,     0},
    '{400,  -131072, 0,     3},
    '{40,   131071,  -6000, 5},
    '{8,    2,       2,     1}
  };

  logic                         clk = 1'b0;
  logic                         rstN;
  logic                         startPulse;
  logic [LEN_W-1:0]             winLen;
  logic                         sampleValid;
  logic [SAMPLE_W-1:0]          sampleData;
  logic [TS_W-1:0]              timeNow = 48'd1000;
  logic                         resValid;
  logic [ACC_W-1:0]             resTotal;
  logic [3:0][ACC_W-1:0]        resTime;
  logic [3:0][ACC_W-1:0]        resIlv;
  logic [TS_W-1:0]              resStamp;
  logic [LEN_W-1:0]             resCount;
  logic                         resLenErr;

  int     nChecks = 0;
  int     nFail   = 0;
  longint lastTotal;

  always #2 clk = ~clk;
  always @(posedge clk) timeNow <= timeNow + 48'd3;

  hwin_integrator #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .TS_W(TS_W), .LEN_W(LEN_W)
  ) u_hwin_integrator (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .winLen(winLen),
    .sampleValid(sampleValid), .sampleData(sampleData), .timeNow(timeNow),
    .resValid(resValid), .resTotal(resTotal), .resTime(resTime),
    .resIlv(resIlv), .resStamp(resStamp), .resCount(resCount),
    .resLenErr(resLenErr)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one window starting at the current negedge, ends at the negedge
  // where the results are visible. intrudeAt >= 0 sends a second start
  // strobe (length 4) while the window is open.
  task automatic runWindow(input int len, input int base, input int step,
                           input int gap, input int intrudeAt);
    longint eTot = 0;
    longint eT[4] = '{0, 0, 0, 0};
    longint eI[4] = '{0, 0, 0, 0};
    longint stamp = 0;
    int q = len / 4;
    for (int i = 0; i < len; i++) begin
      longint s = longint'(base) + longint'(step) * i;
      int sub;
      if (q == 0) sub = 3;
      else sub = (i / q > 3) ? 3 : i / q;
      eTot += s;
      eT[sub] += s;
      eI[i % 4] += s;
    end
    for (int i = 0; i < len; i++) begin
      longint s = longint'(base) + longint'(step) * i;
      if (i > 0) @(negedge clk);
      startPulse = (i == 0) || (i == intrudeAt);
      winLen     = (i == 0) ? LEN_W'(len) : LEN_W'(4);
      if (i == 0) stamp = longint'(timeNow);
      sampleValid = 1'b1;
      sampleData  = s[SAMPLE_W-1:0];
      if (gap > 0 && ((i + 1) % gap == 0) && i != len - 1) begin
        @(negedge clk);
        startPulse  = 1'b0;
        sampleValid = 1'b0;
        sampleData  = '1;
      end
    end
    @(negedge clk);
    startPulse  = 1'b0;
    sampleValid = 1'b0;
    chk("R6", "valid pulse", longint'(resValid), 1);
    chk("R2", "total", longint'(resTotal), eTot);
    chk("R1 R9", "count", longint'(resCount), len);
    chk("R5", "stamp", longint'(resStamp), stamp);
    chk("R7", "length error", longint'(resLenErr), (len % 4 != 0) ? 1 : 0);
    for (int k = 0; k < 4; k++) begin
      chk("R3", $sformatf("time sub %0d", k), longint'(resTime[k]), eT[k]);
      chk("R4", $sformatf("ilv sub %0d", k), longint'(resIlv[k]), eI[k]);
    end
    lastTotal = eTot;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN        = 1'b0;
    startPulse  = 1'b0;
    winLen      = '0;
    sampleValid = 1'b0;
    sampleData  = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10", "valid in reset", longint'(resValid), 0);
    chk("R10", "total in reset", longint'(resTotal), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", "valid after reset", longint'(resValid), 0);
    chk("R10", "count after reset", longint'(resCount), 0);
    chk("R10", "stamp after reset", longint'(resStamp), 0);

    // Table walk: windows run back to back (R9)
    for (int v = 0; v < NVEC; v++)
      runWindow(VECS[v].len, VECS[v].base, VECS[v].step, VECS[v].gap, -1);

    // R6: results hold while idle
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R6", "valid idle", longint'(resValid), 0);
      chk("R6", "total held", longint'(resTotal), lastTotal);
    end

    // R8: zero-length start ignored
    startPulse  = 1'b1;
    winLen      = '0;
    sampleValid = 1'b1;
    sampleData  = 18'd7;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R8", "no window on zero length", longint'(resValid), 0);
    end
    startPulse  = 1'b0;
    sampleValid = 1'b0;
    @(negedge clk);
    chk("R8", "total after zero length", longint'(resTotal), lastTotal);

    // R8: start during an open window ignored (count stays 8)
    runWindow(8, 10, 1, 0, 3);

    // R9: back-to-back after a directed window with gaps
    runWindow(4, -3, -1, 2, -1);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule